// File: doc/BRIEF.md
# Serial Converter Host Controller

This block is the host-side master for an 8-bit serial analog-to-digital converter. A request carries a channel number, a flag choosing single-ended or differential input, a polarity flag and an option to verify the result. The controller lowers chip select and clocks out a start bit followed by a four-bit assignment word. It then releases its data driver and issues one settling clock. After that it shifts in the conversion result, most significant bit first.

When verification is requested, the controller keeps clocking. It collects the seven further bits that the converter replays least significant bit first, rebuilds the value and compares it with the first copy. The result comes back with a one-cycle done pulse and a mismatch flag.

The serial clock is made from the system clock by a fixed half-period divider. `DIV_HALF` must be chosen so that the serial clock stays between 10 kHz and 400 kHz. Each half of the serial clock must also be at least 1.5 us long, because that is the time the converter's output is allowed to take to settle. The default of 100 at 50 MHz gives 250 kHz.

Top module: `sadc_host`

## Requirements
- R1: After reset, `cs_n` is 1, `ser_clk` is 0, `ser_dout_en` is 0, `done` is 0 and `req_ready` is 1.
- R2: An accepted request drives `cs_n` low on the same edge. `cs_n` stays low until the last result bit has been sampled. `ser_clk` is low whenever `cs_n` changes.
- R3: Every high half and every low half of `ser_clk` lasts exactly `DIV_HALF` system clocks while `cs_n` is low. This includes the low half that follows the fall of `cs_n` and the low half that precedes the rise of `cs_n`.
- R4: Rising edges 1 to 5 carry, in order, a 1, then `req_single`, `req_sign`, `req_chan[1]` and `req_chan[0]`. Each bit is stable for `DIV_HALF` cycles before its rising edge and for `DIV_HALF` cycles after it.
- R5: `ser_dout_en` is 1 at rising edges 1 to 5 only. It is 0 from the falling edge after rising edge 5 until the next transaction.
- R6: A transaction has 13 serial clock pulses without verification and 20 with it. The bit present on `ser_din` during the sixth low half, which is the settling interval, never reaches the result.
- R7: `ser_din` is sampled at the end of each low half that follows falling edges 6 to 13. Those eight samples form `result`, most significant bit first.
- R8: With verification, the samples after falling edges 14 to 20 are taken as result bits 1 to 7 in ascending order. `mismatch` is 1 when any of them differs from the corresponding bit of `result`. Without verification, `mismatch` is 0.
- R9: `done` is high for exactly one cycle, on the edge where `cs_n` rises. `result` and `mismatch` are valid then and hold until the next `done`.
- R10: `req_ready` is 0 while a transaction or its gap is in progress. `req_valid` during that time has no effect: it causes no extra transaction and does not alter the word being sent.
- R11: Between transactions `cs_n` stays high for at least 2*`DIV_HALF` system clocks before it can fall again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when `req_ready` is 1 |
| req_chan | input | CHAN_W | Channel number |
| req_single | input | 1 | 1 for single-ended input, 0 for differential |
| req_sign | input | 1 | Polarity / odd-channel flag |
| req_verify | input | 1 | Also read and compare the reversed replay |
| req_ready | output | 1 | Controller idle and gap elapsed |
| cs_n | output | 1 | Converter chip select, active low |
| ser_clk | output | 1 | Serial clock to the converter |
| ser_dout | output | 1 | Host data to the converter |
| ser_dout_en | output | 1 | Enable for the host data driver on a shared wire |
| ser_din | input | 1 | Data from the converter |
| done | output | 1 | One-cycle completion pulse |
| result | output | RES_W | Converted value |
| mismatch | output | 1 | Reversed replay disagreed with the result |

## Verification
The case that is hardest to reach from the ports is a request arriving while a conversion is already in flight. To prove it is ignored, the address bits already captured must stay as they were and no second chip-select cycle may follow. The bench therefore raises `req_valid` with different fields partway through one transaction. It then compares the captured assignment word with the one expected and counts chip-select falls against requests issued.

The converter model also drives a 1 during the settling slot, so that a settling bit leaking into the result would show up. It can corrupt one bit of the reversed replay, so that `mismatch` is exercised both with and without verification.

// File: rtl/sadc_pkg.sv
package sadc_pkg;

  // Phases of one serial transaction
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_LOW,
    PH_HIGH,
    PH_GAP
  } phase_t;

  // Serial half-periods of chip-select-high time between transactions
  localparam int GAP_HALVES = 2;

endpackage

// File: rtl/sadc_divider.sv
module sadc_divider #(
  parameter int DIV_HALF = 100
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  output logic tick
);
  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(DIV_HALF - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  initial begin
    if (DIV_HALF < 2) $error("DIV_HALF must be at least 2");
  end

endmodule

// File: rtl/sadc_sequencer.sv
module sadc_sequencer
  import sadc_pkg::*;
#(
  parameter int DIV_HALF  = 100,
  parameter int ADDR_N    = 5,
  parameter int BASE_N    = 13,
  parameter int FULL_N    = 20,
  parameter int FIRST_SMP = 7,
  parameter int K_W       = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              req_valid,
  input  logic [ADDR_N-1:0] frame_in,
  input  logic              verify_in,
  output logic              accept,
  output logic              ready,
  output logic              sclk,
  output logic              cs_n,
  output logic              sdo,
  output logic              oe,
  output logic              smp_stb,
  output logic              finish,
  output logic              verify_q
);
  localparam int GAP_CYC = GAP_HALVES * DIV_HALF;
  localparam int HW      = $clog2(GAP_CYC + 1);
  localparam int GW      = $clog2(GAP_HALVES + 1);

  phase_t            ph;
  logic [K_W-1:0]    k;
  logic [ADDR_N-1:0] frame_q;
  logic [GW-1:0]     gcnt;
  logic [K_W-1:0]    last_pulse;
  logic [HW-1:0]     hi_cnt;

  assign last_pulse = verify_q ? K_W'(FULL_N) : K_W'(BASE_N);
  assign accept     = req_valid && ready;
  assign smp_stb    = (ph == PH_LOW) && tick && (k >= K_W'(FIRST_SMP));
  assign finish     = (ph == PH_LOW) && tick && (k > last_pulse);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_IDLE;
      k        <= '0;
      frame_q  <= '0;
      gcnt     <= '0;
      ready    <= 1'b1;
      sclk     <= 1'b0;
      cs_n     <= 1'b1;
      sdo      <= 1'b0;
      oe       <= 1'b0;
      verify_q <= 1'b0;
    end else begin
      case (ph)
        PH_IDLE: begin
          if (accept) begin
            ph       <= PH_LOW;
            k        <= K_W'(1);
            cs_n     <= 1'b0;
            oe       <= 1'b1;
            sdo      <= frame_in[ADDR_N-1];
            frame_q  <= frame_in << 1;
            verify_q <= verify_in;
            ready    <= 1'b0;
          end
        end
        PH_LOW: begin
          if (tick) begin
            if (finish) begin
              ph   <= PH_GAP;
              cs_n <= 1'b1;
              gcnt <= '0;
            end else begin
              ph   <= PH_HIGH;
              sclk <= 1'b1;
            end
          end
        end
        PH_HIGH: begin
          if (tick) begin
            sclk <= 1'b0;
            ph   <= PH_LOW;
            k    <= k + 1'b1;
            if (k < K_W'(ADDR_N)) begin
              oe      <= 1'b1;
              sdo     <= frame_q[ADDR_N-1];
              frame_q <= frame_q << 1;
            end else begin
              oe  <= 1'b0;
              sdo <= 1'b0;
            end
          end
        end
        PH_GAP: begin
          if (tick) begin
            if (gcnt == GW'(GAP_HALVES - 1)) begin
              ph    <= PH_IDLE;
              ready <= 1'b1;
            end else begin
              gcnt <= gcnt + 1'b1;
            end
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // Chip-select high time, saturating; used by the gap check
  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= HW'(GAP_CYC);
    end else if (!cs_n) begin
      hi_cnt <= '0;
    end else if (hi_cnt != HW'(GAP_CYC)) begin
      hi_cnt <= hi_cnt + 1'b1;
    end
  end

  AST_CS_HELD: assert property (@(posedge clk) disable iff (rst)
    (ph == PH_LOW || ph == PH_HIGH) |-> !cs_n); // R2
  AST_CS_CLK_LOW: assert property (@(posedge clk) disable iff (rst)
    !$stable(cs_n) |-> (!sclk && !$past(sclk))); // R2
  AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    !$stable(sclk) |-> $past(tick)); // R3
  AST_DRIVE_ADDR_ONLY: assert property (@(posedge clk) disable iff (rst)
    oe |-> (k <= K_W'(ADDR_N))); // R5
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> ($past(ready) && $past(req_valid))); // R10
  AST_GAP_LEN: assert property (@(posedge clk) disable iff (rst)
    $fell(cs_n) |-> (hi_cnt >= HW'(GAP_CYC))); // R11

endmodule

// File: rtl/sadc_collector.sv
module sadc_collector #(
  parameter int RES_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             smp_stb,
  input  logic             sdi,
  input  logic             finish,
  input  logic             verify,
  output logic             done,
  output logic [RES_W-1:0] result,
  output logic             mismatch
);
  localparam int SW = $clog2(2 * RES_W);

  logic [SW-1:0]    sidx;
  logic [RES_W-1:0] msb_q, msb_nxt;
  logic [RES_W-2:0] lsb_q, lsb_nxt;
  logic             take_msb, take_lsb;

  assign take_msb = smp_stb && (sidx < SW'(RES_W));
  assign take_lsb = smp_stb && (sidx >= SW'(RES_W));
  assign msb_nxt  = take_msb ? {msb_q[RES_W-2:0], sdi} : msb_q;
  assign lsb_nxt  = take_lsb ? {sdi, lsb_q[RES_W-2:1]} : lsb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sidx     <= '0;
      msb_q    <= '0;
      lsb_q    <= '0;
      done     <= 1'b0;
      result   <= '0;
      mismatch <= 1'b0;
    end else begin
      done <= finish;
      if (start) begin
        sidx  <= '0;
        msb_q <= '0;
        lsb_q <= '0;
      end else begin
        msb_q <= msb_nxt;
        lsb_q <= lsb_nxt;
        if (smp_stb) sidx <= sidx + 1'b1;
      end
      if (finish) begin
        result   <= msb_nxt;
        mismatch <= verify && (lsb_nxt != msb_nxt[RES_W-1:1]);
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_SAMPLE_COUNT: assert property (@(posedge clk) disable iff (rst)
    finish |-> (smp_stb && sidx == (verify ? SW'(2*RES_W-2) : SW'(RES_W-1)))); // R6
  AST_PLAIN_NO_MISMATCH: assert property (@(posedge clk) disable iff (rst)
    (finish && !verify) |=> !mismatch); // R8

endmodule

// File: rtl/sadc_host.sv
module sadc_host #(
  parameter int DIV_HALF = 100,
  parameter int CHAN_W   = 2,
  parameter int RES_W    = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CHAN_W-1:0] req_chan,
  input  logic              req_single,
  input  logic              req_sign,
  input  logic              req_verify,
  output logic              req_ready,
  output logic              cs_n,
  output logic              ser_clk,
  output logic              ser_dout,
  output logic              ser_dout_en,
  input  logic              ser_din,
  output logic              done,
  output logic [RES_W-1:0]  result,
  output logic              mismatch
);
  localparam int WORD_W    = CHAN_W + 2;
  localparam int ADDR_N    = WORD_W + 1;
  localparam int BASE_N    = ADDR_N + RES_W;
  localparam int FULL_N    = BASE_N + RES_W - 1;
  localparam int FIRST_SMP = ADDR_N + 2;
  localparam int K_W       = $clog2(FULL_N + 2);

  logic              tick, accept, smp_stb, finish, verify_q;
  logic [ADDR_N-1:0] frame;

  assign frame = {1'b1, req_single, req_sign, req_chan};

  sadc_divider #(.DIV_HALF(DIV_HALF)) u_div (
    .clk   (clk),
    .rst   (rst),
    .clear (accept),
    .tick  (tick)
  );

  sadc_sequencer #(
    .DIV_HALF  (DIV_HALF),
    .ADDR_N    (ADDR_N),
    .BASE_N    (BASE_N),
    .FULL_N    (FULL_N),
    .FIRST_SMP (FIRST_SMP),
    .K_W       (K_W)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .req_valid (req_valid),
    .frame_in  (frame),
    .verify_in (req_verify),
    .accept    (accept),
    .ready     (req_ready),
    .sclk      (ser_clk),
    .cs_n      (cs_n),
    .sdo       (ser_dout),
    .oe        (ser_dout_en),
    .smp_stb   (smp_stb),
    .finish    (finish),
    .verify_q  (verify_q)
  );

  sadc_collector #(.RES_W(RES_W)) u_col (
    .clk      (clk),
    .rst      (rst),
    .start    (accept),
    .smp_stb  (smp_stb),
    .sdi      (ser_din),
    .finish   (finish),
    .verify   (verify_q),
    .done     (done),
    .result   (result),
    .mismatch (mismatch)
  );

  AST_DONE_WITH_CS: assert property (@(posedge clk) disable iff (rst)
    done |-> $rose(cs_n)); // R9

endmodule

// File: tb/sadc_host_test.sv
`timescale 1ns/1ps
module sadc_host_test;
  localparam int DIV = 100;

  typedef struct {
    logic [3:0] word;
    logic [7:0] code;
    logic       mism;
    int         pulses;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_chan = '0;
  logic       req_single = 1'b0, req_sign = 1'b0, req_verify = 1'b0;
  logic       req_ready, cs_n, ser_clk, ser_dout, ser_dout_en, done, mismatch;
  logic       ser_din = 1'b1;
  logic [7:0] result;

  int total = 0, failed = 0;
  int requests = 0, cs_falls = 0;
  exp_t q[$];

  logic [7:0] nxt_code, cur_code;
  logic       nxt_bad = 1'b0, cur_bad;

  always #10 clk = ~clk;

  sadc_host #(.DIV_HALF(DIV)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_chan(req_chan),
    .req_single(req_single), .req_sign(req_sign), .req_verify(req_verify),
    .req_ready(req_ready), .cs_n(cs_n), .ser_clk(ser_clk), .ser_dout(ser_dout),
    .ser_dout_en(ser_dout_en), .ser_din(ser_din), .done(done),
    .result(result), .mismatch(mismatch)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Converter model and monitor, sampled away from the active edge
  logic       p_sclk = 1'b0, p_cs = 1'b1, p_sdo = 1'b0, p_done = 1'b0;
  int         run = 0, sdo_stab = 0, since_rise = 0, cs_hi = 0;
  int         rises = 0, falls = 0, last_pulses = 0, n_cs_hi = 0;
  logic [3:0] word_cap = '0;
  logic [7:0] held_res = '0;
  bit         have_res = 0;

  always @(negedge clk) begin
    if (!rst) begin
      run++; sdo_stab++; since_rise++; cs_hi++;
      if (p_done) chk(done == 1'b0, "R9 done width", done, 0);
      if (p_cs && !cs_n) begin
        cs_falls++;
        if (cs_falls > 1) chk(cs_hi >= 2*DIV, "R11 cs high gap", cs_hi, 2*DIV);
        if (have_res) chk(result == held_res, "R9 result held", result, held_res);
        chk(ser_clk == 1'b0, "R2 clock low at cs fall", ser_clk, 0);
        rises = 0; falls = 0; word_cap = '0; run = 0;
        cur_code = nxt_code; cur_bad = nxt_bad; ser_din = 1'b1;
      end
      if (!cs_n && ser_dout != p_sdo) begin
        if (rises > 0) chk(since_rise >= DIV, "R4 hold after rise", since_rise, DIV);
        sdo_stab = 0;
      end
      if (!cs_n && ser_clk && !p_sclk) begin
        rises++;
        chk(run == DIV, "R3 low half", run, DIV);
        if (rises <= 5) begin
          chk(ser_dout_en == 1'b1, "R5 driver on in address", ser_dout_en, 1);
          chk(sdo_stab >= DIV, "R4 setup before rise", sdo_stab, DIV);
          if (rises > 1) word_cap = {word_cap[2:0], ser_dout};
          else chk(ser_dout == 1'b1, "R4 start bit", ser_dout, 1);
        end else begin
          chk(ser_dout_en == 1'b0, "R5 driver off after address", ser_dout_en, 0);
        end
        run = 0; since_rise = 0;
      end
      if (!cs_n && !ser_clk && p_sclk) begin
        falls++;
        chk(run == DIV, "R3 high half", run, DIV);
        if (falls <= 5) ser_din = 1'b1;             // settling slot driven 1 (R6)
        else if (falls <= 13) ser_din = cur_code[13 - falls];
        else if (falls <= 20) ser_din = cur_code[falls - 13] ^ (cur_bad && (falls - 13 == 4));
        else ser_din = 1'b0;
        run = 0;
      end
      if (!p_cs && cs_n) begin
        chk(ser_clk == 1'b0, "R2 clock low at cs rise", ser_clk, 0);
        chk(run == DIV, "R3 final low half", run, DIV);
        last_pulses = rises; cs_hi = 0;
      end
      if (cs_n && !p_cs) cs_hi = 0;
      if (done) begin
        exp_t e;
        if (q.size() == 0) begin
          chk(0, "R9 unexpected done", 1, 0);
        end else begin
          e = q.pop_front();
          chk(cs_n == 1'b1, "R9 done with cs rise", cs_n, 1);
          chk(result == e.code, "R7 result", result, e.code);
          chk(mismatch == e.mism, "R8 mismatch", mismatch, e.mism);
          chk(word_cap == e.word, "R4 assignment word", word_cap, e.word);
          chk(last_pulses == e.pulses, "R6 pulse count", last_pulses, e.pulses);
          held_res = result; have_res = 1;
        end
      end
      p_sclk = ser_clk; p_cs = cs_n; p_sdo = ser_dout; p_done = done;
    end
  end

  task automatic run_txn(input logic [1:0] ch, input logic sgl, input logic sgn,
                         input logic ver, input logic [7:0] code, input logic bad,
                         input bit poke);
    exp_t e;
    while (!req_ready) @(negedge clk);
    nxt_code = code; nxt_bad = bad;
    e.word = {sgl, sgn, ch}; e.code = code;
    e.mism = ver && bad; e.pulses = ver ? 20 : 13;
    q.push_back(e);
    requests++;
    req_chan = ch; req_single = sgl; req_sign = sgn; req_verify = ver;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (300) @(negedge clk);
      chk(req_ready == 1'b0, "R10 not ready while busy", req_ready, 0);
      req_chan = ~ch; req_single = ~sgl; req_sign = ~sgn; req_verify = ~ver;
      req_valid = 1'b1;
      repeat (5) @(negedge clk);
      req_valid = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failed++; total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    nxt_code = '0; cur_code = '0; cur_bad = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1 cs_n reset", cs_n, 1);
    chk(ser_clk == 1'b0, "R1 ser_clk reset", ser_clk, 0);
    chk(ser_dout_en == 1'b0, "R1 driver reset", ser_dout_en, 0);
    chk(done == 1'b0, "R1 done reset", done, 0);
    chk(req_ready == 1'b1, "R1 ready reset", req_ready, 1);

    run_txn(2'd0, 1'b1, 1'b0, 1'b0, 8'hA5, 1'b0, 0);
    run_txn(2'd3, 1'b1, 1'b1, 1'b1, 8'h00, 1'b0, 0);
    run_txn(2'd1, 1'b0, 1'b1, 1'b1, 8'hFF, 1'b0, 0);
    run_txn(2'd2, 1'b0, 1'b0, 1'b1, 8'h3C, 1'b1, 0);   // R8 corrupted replay
    run_txn(2'd1, 1'b1, 1'b0, 1'b0, 8'h81, 1'b1, 0);   // R8 corruption unseen
    run_txn(2'd2, 1'b1, 1'b1, 1'b1, 8'h5A, 1'b0, 1);   // R10 busy request
    run_txn(2'd2, 1'b1, 1'b0, 1'b1, 8'h01, 1'b0, 0);

    repeat (4*DIV) @(negedge clk);
    chk(cs_falls == requests, "R10 transactions vs requests", cs_falls, requests);
    chk(cs_n == 1'b1, "R10 no extra transaction", cs_n, 1);
    chk(q.size() == 0, "R9 all results returned", q.size(), 0);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

endmodule